// File: doc/BRIEF.md
# ROM Entry List Walker

This block steps through the chain of variable-length entries that follows the fixed header of a device configuration ROM image. The image sits in a byte-wide RAM with a one-cycle read latency. After a start pulse the walker reads the first two bytes of each entry: a length byte that counts the whole entry, and an attribute byte that holds an index, a disabled flag and a type flag. From these it forms a decoded record, or it skips the entry, and it then jumps ahead by the entry length.

Records leave on a valid/ready handshake, and the walk pauses for as long as the consumer holds ready low. A walk ends in exactly one of two ways. The done pulse fires when the position lands exactly on the image size. The overrun pulse fires when the chain is malformed. Copying payload bytes and reacting to an overrun are left to the consumer.

Top module: `rom_entry_walker`

## Requirements
- R1: A start pulse while idle sets the position to `START_POS` and the image size to `data_len + DATA_BASE`. A start pulse while a walk is running has no effect on that walk.
- R2: For an entry at position p, the length byte is read from address p and the attribute byte from p+1. Attribute bits [5:0] hold the index, bit 6 holds the disabled flag, and bit 7 holds the type (0 = generic, 1 = port).
- R3: Each emitted record carries the entry position, the length byte, the index, the type, and a body length equal to the length byte minus 2.
- R4: The disabled flag is reported only on port records. On generic records it always reads 0.
- R5: A port entry whose index is greater than `max_port` is skipped with no record, and the walk goes on. A port entry whose index equals `max_port` is emitted. Generic entries are never skipped, whatever their index.
- R6: Records come out in chain order, and each following entry starts at the previous position plus its length byte.
- R7: When the position equals the image size, `done` pulses high for one cycle and `busy` falls in that same cycle.
- R8: If exactly one byte is left before the image size, the walk ends with an `overrun` pulse and reads no length byte.
- R9: If position plus length byte is greater than the image size, the walk ends with an `overrun` pulse.
- R10: A length byte of 0 or 1 ends the walk with an `overrun` pulse.
- R11: If the image size is smaller than `START_POS`, the walk ends at once with an `overrun` pulse.
- R12: While `rec_valid` is high and `rec_ready` is low, the record holds steady and the walk does not move on.
- R13: After reset the block is idle, with `busy`, `rec_valid`, `done`, `overrun` and `mem_rd` all low.
- R14: Each walk ends with exactly one of `done` or `overrun`, and never with both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (used only while idle) |
| data_len | input | LEN_W | Data length field of the image header |
| max_port | input | 6 | Highest valid port index |
| mem_rd | output | 1 | RAM read strobe |
| mem_addr | output | LEN_W+1 | RAM byte address |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the strobe |
| rec_valid | output | 1 | Decoded record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_pos | output | LEN_W+1 | Byte position of the entry |
| rec_len | output | 8 | Total entry length |
| rec_body_len | output | 8 | Entry length without its 2-byte header |
| rec_index | output | 6 | Entry index |
| rec_is_port | output | 1 | 1 = port entry, 0 = generic entry |
| rec_disabled | output | 1 | Disabled flag (port entries only) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: clean end of the chain |
| overrun | output | 1 | One-cycle pulse: malformed chain |

## Verification
The bench builds the walker with an 8-bit data length, a header of 6 bytes and a size offset of 3, so every image fits into a 512-byte model RAM. Under this setting a sweep over dozens of generated chains becomes practical. It covers every chain length from empty to seven entries, each of the tail faults, and index values on both sides of the port limit. It runs under three ready patterns, one of which also fires a stray start in the middle of a walk. A short header setting also lets the too-small image and the empty chain each be set up with a single data length value.

// File: rtl/rom_walk_pkg.sv
`timescale 1ns/1ps
package rom_walk_pkg;

    typedef enum logic [2:0] {
        W_IDLE,
        W_CHECK,
        W_LEN,
        W_ATTR,
        W_EMIT
    } walk_state_e;

    // Attribute byte: bit 7 type, bit 6 disabled, bits 5:0 index
    typedef struct packed {
        logic       is_port;
        logic       disabled;
        logic [5:0] index;
    } attr_t;

    localparam int unsigned HDR_BYTES = 2;

endpackage

// File: rtl/rom_walk_decode.sv
`timescale 1ns/1ps
module rom_walk_decode
    import rom_walk_pkg::*;
(
    input  logic [7:0] attr_byte,
    input  logic [5:0] max_port,
    output logic [5:0] index,
    output logic       is_port,
    output logic       disabled,
    output logic       skip
);
    attr_t a;

    always_comb begin
        a        = attr_t'(attr_byte);
        index    = a.index;
        is_port  = a.is_port;
        disabled = a.is_port & a.disabled;
        skip     = a.is_port && (a.index > max_port);
    end
endmodule

// File: rtl/rom_walk_bounds.sv
`timescale 1ns/1ps
module rom_walk_bounds
    import rom_walk_pkg::*;
#(
    parameter int POS_W = 17
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] size,
    input  logic [7:0]       len,
    output logic             at_end,
    output logic             tail_short,
    output logic             len_bad
);
    localparam int EXT_W = POS_W + 1;

    logic [EXT_W-1:0] pos_x;
    logic [EXT_W-1:0] size_x;
    logic [EXT_W-1:0] reach_x;

    always_comb begin
        pos_x      = {1'b0, pos};
        size_x     = {1'b0, size};
        reach_x    = pos_x + EXT_W'(len);
        at_end     = (pos == size);
        tail_short = (pos > size) || ((pos_x + EXT_W'(1)) == size_x);
        len_bad    = (len < 8'(HDR_BYTES)) || (reach_x > size_x);
    end
endmodule

// File: rtl/rom_entry_walker.sv
`timescale 1ns/1ps
module rom_entry_walker
    import rom_walk_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int START_POS = 22,
    parameter int DATA_BASE = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   data_len,
    input  logic [5:0]         max_port,
    output logic               mem_rd,
    output logic [LEN_W:0]     mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic               rec_valid,
    input  logic               rec_ready,
    output logic [LEN_W:0]     rec_pos,
    output logic [7:0]         rec_len,
    output logic [7:0]         rec_body_len,
    output logic [5:0]         rec_index,
    output logic               rec_is_port,
    output logic               rec_disabled,
    output logic               busy,
    output logic               done,
    output logic               overrun
);
    localparam int POS_W = LEN_W + 1;
    localparam logic [POS_W-1:0] START_P = POS_W'(START_POS);
    localparam logic [POS_W-1:0] BASE_P  = POS_W'(DATA_BASE);

    typedef struct packed {
        walk_state_e       st;
        logic [POS_W-1:0]  pos;
        logic [POS_W-1:0]  size;
        logic [7:0]        len;
        logic [7:0]        attr;
        logic              done;
        logic              ovr;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [7:0]       dec_in;
    logic [5:0]       dec_index;
    logic             dec_port;
    logic             dec_dis;
    logic             dec_skip;
    logic [7:0]       bnd_len;
    logic             at_end;
    logic             tail_short;
    logic             len_bad;
    logic [POS_W-1:0] next_pos;
    logic [POS_W-1:0] size_w;

    assign dec_in   = (r_q.st == W_ATTR) ? mem_rdata : r_q.attr;
    assign bnd_len  = (r_q.st == W_LEN) ? mem_rdata : r_q.len;
    assign next_pos = r_q.pos + POS_W'(r_q.len);
    assign size_w   = r_q.size;

    rom_walk_decode u_decode (
        .attr_byte (dec_in),
        .max_port  (max_port),
        .index     (dec_index),
        .is_port   (dec_port),
        .disabled  (dec_dis),
        .skip      (dec_skip)
    );

    rom_walk_bounds #(.POS_W(POS_W)) u_bounds (
        .pos        (r_q.pos),
        .size       (r_q.size),
        .len        (bnd_len),
        .at_end     (at_end),
        .tail_short (tail_short),
        .len_bad    (len_bad)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ovr  = 1'b0;
        mem_rd   = 1'b0;
        mem_addr = r_q.pos;
        unique case (r_q.st)
            W_IDLE: begin
                if (start) begin
                    r_d.pos  = START_P;
                    r_d.size = {1'b0, data_len} + BASE_P;
                    r_d.st   = W_CHECK;
                end
            end
            W_CHECK: begin
                if (at_end) begin
                    r_d.done = 1'b1;
                    r_d.st   = W_IDLE;
                end else if (tail_short) begin
                    r_d.ovr = 1'b1;
                    r_d.st  = W_IDLE;
                end else begin
                    mem_rd = 1'b1;
                    r_d.st = W_LEN;
                end
            end
            W_LEN: begin
                r_d.len = mem_rdata;
                if (len_bad) begin
                    r_d.ovr = 1'b1;
                    r_d.st  = W_IDLE;
                end else begin
                    mem_rd   = 1'b1;
                    mem_addr = r_q.pos + POS_W'(1);
                    r_d.st   = W_ATTR;
                end
            end
            W_ATTR: begin
                r_d.attr = mem_rdata;
                if (dec_skip) begin
                    r_d.pos = next_pos;
                    r_d.st  = W_CHECK;
                end else begin
                    r_d.st = W_EMIT;
                end
            end
            W_EMIT: begin
                if (rec_ready) begin
                    r_d.pos = next_pos;
                    r_d.st  = W_CHECK;
                end
            end
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: W_IDLE, pos: '0, size: '0, len: '0, attr: '0,
                     done: 1'b0, ovr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rec_valid    = (r_q.st == W_EMIT);
    assign rec_pos      = r_q.pos;
    assign rec_len      = r_q.len;
    assign rec_body_len = r_q.len - 8'(HDR_BYTES);
    assign rec_index    = dec_index;
    assign rec_is_port  = dec_port;
    assign rec_disabled = dec_dis;
    assign busy         = (r_q.st != W_IDLE);
    assign done         = r_q.done;
    assign overrun      = r_q.ovr;

endmodule

// File: rtl/rom_walk_checker.sv
`timescale 1ns/1ps
module rom_walk_checker #(
    parameter int POS_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [POS_W-1:0] rec_pos,
    input logic [7:0]       rec_len,
    input logic [5:0]       rec_index,
    input logic             rec_is_port,
    input logic             rec_disabled,
    input logic [5:0]       max_port,
    input logic             mem_rd,
    input logic [POS_W-1:0] mem_addr,
    input logic [POS_W-1:0] size,
    input logic             busy,
    input logic             done,
    input logic             overrun
);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid &&
        $stable({rec_pos, rec_len, rec_index, rec_is_port, rec_disabled}));

    assert_port_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_is_port |-> rec_index <= max_port);

    assert_generic_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_is_port |-> !rec_disabled);

    assert_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ({1'b0, rec_pos} + (POS_W+1)'(rec_len)) <= {1'b0, size});

    assert_min_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> rec_len >= 8'd2);

    assert_one_end_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && overrun));

    assert_idle_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || overrun) |-> !busy);

    assert_read_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr < size);

    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready |=> !rec_valid && busy);
endmodule

bind rom_entry_walker rom_walk_checker #(.POS_W(POS_W)) u_walk_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_valid    (rec_valid),
    .rec_ready    (rec_ready),
    .rec_pos      (rec_pos),
    .rec_len      (rec_len),
    .rec_index    (rec_index),
    .rec_is_port  (rec_is_port),
    .rec_disabled (rec_disabled),
    .max_port     (max_port),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .size         (size_w),
    .busy         (busy),
    .done         (done),
    .overrun      (overrun)
);

// File: tb/test_rom_entry_walker.sv
`timescale 1ns/1ps
module test_rom_entry_walker;
    localparam int LEN_W = 8;
    localparam int START = 6;
    localparam int BASE  = 3;
    localparam int POS_W = LEN_W + 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [LEN_W-1:0] data_len;
    logic [5:0]       max_port;
    logic             mem_rd;
    logic [POS_W-1:0] mem_addr;
    logic [7:0]       mem_rdata;
    logic             rec_valid;
    logic             rec_ready;
    logic [POS_W-1:0] rec_pos;
    logic [7:0]       rec_len;
    logic [7:0]       rec_body_len;
    logic [5:0]       rec_index;
    logic             rec_is_port;
    logic             rec_disabled;
    logic             busy;
    logic             done;
    logic             overrun;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [0:511];
    int e_pos [0:15];
    int e_len [0:15];
    int e_idx [0:15];
    int e_port[0:15];
    int e_dis [0:15];
    int e_cnt;
    int e_ovr;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    rom_entry_walker #(.LEN_W(LEN_W), .START_POS(START), .DATA_BASE(BASE)) i_rom_entry_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .data_len(data_len),
        .max_port(max_port), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_pos(rec_pos), .rec_len(rec_len), .rec_body_len(rec_body_len),
        .rec_index(rec_index), .rec_is_port(rec_is_port),
        .rec_disabled(rec_disabled), .busy(busy), .done(done), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build(input int seed, input int kind, output int dl, output int mp);
        int p;
        int n;
        for (int k = 0; k < 512; k++) mem[k] = 8'hA5;
        mp = 20 + seed % 5;
        p  = START;
        n  = (kind == 4) ? 0 : (kind == 5) ? 3 + seed % 5 : 1 + seed % 7;
        for (int i = 0; i < n; i++) begin
            int len;
            int port;
            int idx;
            int dis;
            len  = 2 + (seed * 7 + i * 5) % 9;
            port = (seed + i) % 2;
            idx  = (seed * 3 + i * 11) % 64;
            dis  = ((i + seed) % 3 == 0) ? 1 : 0;
            if (kind == 5) begin
                if (i == 0) begin port = 1; idx = mp;     end
                if (i == 1) begin port = 1; idx = mp + 1; end
                if (i == 2) begin port = 0; idx = 63; dis = 1; end
            end
            // R2 layout: bit 7 type, bit 6 disabled, bits 5:0 index
            mem[p]     = 8'(len);
            mem[p + 1] = {port[0], dis[0], idx[5:0]};
            for (int j = 2; j < len; j++) mem[p + j] = 8'(i);
            p += len;
        end
        case (kind)
            1: dl = p + 1 - BASE;
            2: begin mem[p] = 8'd5; mem[p + 1] = 8'h00; dl = p + 3 - BASE; end
            3: begin mem[p] = 8'(seed % 2); mem[p + 1] = 8'h00; dl = p + 4 - BASE; end
            default: dl = p - BASE;
        endcase
    endtask

    task automatic model(input int dl, input int mp);
        int p;
        int size;
        p = START;
        size = dl + BASE;
        e_cnt = 0;
        e_ovr = 0;
        for (int guard = 0; guard < 300; guard++) begin
            int len;
            logic [7:0] a;
            if (p == size) break;
            if (p > size || p + 1 == size) begin e_ovr = 1; break; end
            len = int'(mem[p]);
            if (len < 2 || p + len > size) begin e_ovr = 1; break; end
            a = mem[p + 1];
            if (!(a[7] && int'(a[5:0]) > mp)) begin
                e_pos[e_cnt]  = p;
                e_len[e_cnt]  = len;
                e_idx[e_cnt]  = int'(a[5:0]);
                e_port[e_cnt] = int'(a[7]);
                e_dis[e_cnt]  = a[7] ? int'(a[6]) : 0;
                e_cnt++;
            end
            p += len;
        end
    endtask

    task automatic run(input int dl, input int mp, input int mode,
                       input bit inject, input string end_tag, input string rec_tag);
        int got = 0;
        int fin = 0;
        int saw_ovr = 0;
        bit injected = 0;
        model(dl, mp);
        data_len = LEN_W'(dl);
        max_port = 6'(mp);
        @(negedge clk);
        start = 1'b1;
        for (int cyc = 0; cyc < 3000 && fin == 0; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && !injected && rec_valid && got == 1) begin
                start = 1'b1;   // R1: stray start during a walk
                injected = 1'b1;
            end
            case (mode)
                0: rec_ready = 1'b1;
                1: rec_ready = (cyc % 2) == 1;
                default: rec_ready = (cyc % 4) == 3;
            endcase
            if (rec_valid) begin
                if (got < e_cnt) begin
                    // R3 fields, R2 decode, R4 disabled masking; R12 when held
                    chk(rec_pos == POS_W'(e_pos[got]) && rec_len == 8'(e_len[got]) &&
                        rec_body_len == 8'(e_len[got] - 2) &&
                        rec_index == 6'(e_idx[got]) && rec_is_port == e_port[got][0] &&
                        rec_disabled == e_dis[got][0],
                        rec_ready ? rec_tag : "R12", "record position",
                        longint'(rec_pos), longint'(e_pos[got]));
                end else begin
                    chk(0, "R6", "extra record", got + 1, e_cnt);
                end
                if (rec_ready) got++;
            end
            if (done || overrun) begin
                fin = 1;
                saw_ovr = overrun ? 1 : 0;
                chk(!(done && overrun), "R14", "both end pulses", 2, 1);
                chk(busy == 1'b0, "R7", "busy at end", busy, 0);
            end
        end
        start = 1'b0;
        rec_ready = 1'b0;
        chk(fin == 1, "R14", "walk ended (watchdog)", fin, 1);
        chk(got == e_cnt, "R6", "record count", got, e_cnt);
        chk(saw_ovr == e_ovr, end_tag, "overrun outcome", saw_ovr, e_ovr);
        if (injected) chk(got == e_cnt, "R1", "count after stray start", got, e_cnt);
        @(negedge clk);
        chk(!busy && !done && !overrun, end_tag, "settled idle", busy, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int dl;
        int mp;
        rst_n = 1'b0;
        start = 1'b0;
        rec_ready = 1'b0;
        data_len = '0;
        max_port = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(!busy && !rec_valid && !done && !overrun && !mem_rd, "R13",
            "outputs after reset", {busy, rec_valid, done, overrun, mem_rd}, 0);

        // R11: image smaller than header
        build(1, 0, dl, mp);
        run(2, mp, 0, 0, "R11", "R3");
        // R7: empty chain, size equals header
        run(3, mp, 0, 0, "R7", "R3");

        for (int seed = 0; seed < 48; seed++) begin
            int kind;
            int mode;
            string tag;
            kind = seed % 6;
            mode = (seed / 6) % 3;
            case (kind)
                1: tag = "R8";
                2: tag = "R9";
                3: tag = "R10";
                default: tag = "R7";
            endcase
            build(seed, kind, dl, mp);
            run(dl, mp, mode, mode == 2, tag, (kind == 5) ? "R5" : "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule